// File: doc/BRIEF.md
# Half-Step Fractional Pixel Clock Divider

This block turns a fast source clock into a stream of single-cycle pixel enables whose average rate is the source rate divided by a fixed-point ratio. The ratio is an unsigned divider word whose least significant bit weighs one half of a source period, with an implicit offset of two. A word `d` therefore yields an average spacing of `(d+2)/2` source cycles between enables. When `d` is odd the half cycle cannot be produced directly, so the block alternates a short period and a long period that differ by one cycle. Downstream pixel logic runs on the source clock and advances only in cycles where the enable is high, so no derived clock edge exists anywhere.

The divider word may be changed at any time. The block takes a new word only at the boundary between two output periods, so a period in progress always completes with the length it started with. Dropping the enable stops the pulses at once and clears the internal phase. The shared package also provides a constant function that computes the divider word from a source frequency and a target pixel frequency. It rounds to the nearest half step and clamps to the legal range, so a 600 MHz source with a 75 MHz pixel target gives a word of 14.

Top module: `pixclk_halfstep_div`

## Requirements
- R1: For an even divider word `d` held while enabled, `pix_en` is high once every `d/2+1` source cycles, and the first pulse falls on the `(d/2+1)`-th enabled cycle.
- R2: For an odd divider word `d`, the spacing between successive pulses alternates between `(d+1)/2` and `(d+3)/2` cycles, starting with the shorter one after enable.
- R3: A divider word of 0 makes `pix_en` high in every enabled cycle.
- R4: While `en` is low, `pix_en` is low in the same cycle. The counter and the short/long phase are cleared, so after re-enable the first pulse again comes after the short length.
- R5: A divider word changed during an output period takes effect only after that period's pulse. The period in progress keeps its old length.
- R6: While `rst` is high, `pix_en` is low whatever the other inputs are.
- R7: The package function `calc_divider(src_hz, pix_hz)` returns `floor((2*src_hz + pix_hz/2)/pix_hz) - 2`. The result is clamped to 0 below and to `2^DIV_W-1` above, and a zero `pix_hz` gives the maximum.
- R8: Every pulse lasts exactly one source cycle unless the next period is also one cycle long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable. Low stops the pulses and clears the phase |
| div_val | input | DIV_W | Divider word in 7.1 format, offset by two |
| pix_en | output | 1 | One-cycle pixel enable pulse |

## Verification
The block is driven with even words, which must give uniform spacing, and odd words, which must alternate a short and a long period in that order. The words include 0 and 1 at the bottom of the range and 254 and 255 at the top. That set distinguishes a wrong offset, a wrong half-bit weight, a swapped alternation order and a counter that overflows at the widest setting. Directed sequences then change the word in mid-period, which separates adoption at the period boundary from immediate adoption. They also drop the enable in mid-period, which shows whether the phase is cleared. The helper function is checked at exact, rounding and clamping frequency pairs.

// File: rtl/pixdiv_pkg.sv
package pixdiv_pkg;

    // Width of the divider word (7.1 fixed point when 8)
    localparam int DIV_W = 8;
    localparam longint unsigned DIV_MAX = (64'd1 << DIV_W) - 64'd1;

    typedef logic [DIV_W-1:0] div_t;

    // Which of the two alternating lengths the current period uses
    typedef enum logic {
        PH_SHORT = 1'b0,
        PH_LONG  = 1'b1
    } phase_e;

    // Decoded period description for the active divider word
    typedef struct packed {
        div_t short_len;   // floor((d+2)/2)
        logic odd;         // half step present: alternate short/long
    } period_t;

    function automatic period_t decode_period(input div_t d);
        period_t p;
        p.short_len = (d >> 1) + div_t'(1);
        p.odd       = d[0];
        return p;
    endfunction

    // Divider word from source and pixel frequencies, round to nearest
    function automatic div_t calc_divider(input longint unsigned src_hz,
                                          input longint unsigned pix_hz);
        longint unsigned q;
        if (pix_hz == 64'd0) return div_t'(DIV_MAX);
        q = (src_hz * 64'd2 + pix_hz / 64'd2) / pix_hz;
        if (q < 64'd2) return '0;
        if (q - 64'd2 > DIV_MAX) return div_t'(DIV_MAX);
        return div_t'(q - 64'd2);
    endfunction

endpackage

// File: rtl/pixdiv_setting.sv
module pixdiv_setting
    import pixdiv_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    period_end,
    input  div_t    div_in,
    output period_t per
);

    div_t cur_d;

    // The word is taken while idle or at the end of a period only
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_d <= '0;
        end else if (!en || period_end) begin
            cur_d <= div_in;
        end
    end

    always_comb begin
        per = decode_period(cur_d);
    end

    // R5
    hold_mid_period_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !period_end) |=> $stable(cur_d));

endmodule

// File: rtl/pixdiv_phase.sv
module pixdiv_phase
    import pixdiv_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  period_t per,
    output logic    pulse
);

    div_t   cnt;
    phase_e ph;
    div_t   len;
    logic   last;

    always_comb begin
        len   = per.short_len + div_t'(per.odd && (ph == PH_LONG));
        last  = (cnt == len - div_t'(1));
        pulse = en && !rst && last;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            ph  <= PH_SHORT;
        end else if (last) begin
            cnt <= '0;
            if (per.odd) begin
                ph <= (ph == PH_SHORT) ? PH_LONG : PH_SHORT;
            end else begin
                ph <= PH_SHORT;
            end
        end else begin
            cnt <= cnt + div_t'(1);
        end
    end

    // R4
    idle_quiet_chk: assert property (@(posedge clk) !en |-> !pulse);

    // R4
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0 && ph == PH_SHORT));

    // R6
    reset_quiet_chk: assert property (@(posedge clk) rst |-> !pulse);

    // R3
    every_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (en && per.short_len == div_t'(1) && !per.odd) |-> pulse);

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt < len));

endmodule

// File: rtl/pixclk_halfstep_div.sv
module pixclk_halfstep_div
    import pixdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div_val,
    output logic             pix_en
);

    period_t per;
    logic    pulse;

    pixdiv_setting u_setting (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .period_end (pulse),
        .div_in     (div_val),
        .per        (per)
    );

    pixdiv_phase u_phase (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .per   (per),
        .pulse (pulse)
    );

    assign pix_en = pulse;

endmodule

// File: tb/sim_pixclk_halfstep_div.sv
`timescale 1ns/1ps
module sim_pixclk_halfstep_div;
    import pixdiv_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    div_t div_val = '0;
    logic pix_en;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pixclk_halfstep_div u0 (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .div_val (div_val),
        .pix_en  (pix_en)
    );

    // d, first (short) interval, second interval
    localparam int VEC [8][3] = '{
        '{0,   1,   1},
        '{1,   1,   2},
        '{2,   2,   2},
        '{3,   2,   3},
        '{14,  8,   8},
        '{15,  8,   9},
        '{254, 128, 128},
        '{255, 128, 129}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive inputs just after a rising edge, sample at the falling edge
    task automatic tick(input logic e, input div_t d, output logic p);
        @(posedge clk);
        #1;
        en = e;
        div_val = d;
        @(negedge clk);
        p = pix_en;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 50000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic p;
        int k;
        int last;
        int n;
        int pcount;

        // R6: held in reset with a setting that would pulse every cycle
        en = 1'b1;
        div_val = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pix_en == 1'b0, "R6 reset", int'(pix_en), 0);
        #1;
        en = 1'b0;
        @(posedge clk);
        #1;
        rst = 1'b0;

        // R1 R2 R3 R8: table of settings and expected spacings
        for (int i = 0; i < 8; i++) begin
            tick(1'b0, div_t'(VEC[i][0]), p);
            tick(1'b0, div_t'(VEC[i][0]), p);
            k = 0;
            last = 0;
            n = 0;
            while (n < 4 && k < 600) begin
                tick(1'b1, div_t'(VEC[i][0]), p);
                k++;
                if (p) begin
                    chk((k - last) == ((n % 2 == 0) ? VEC[i][1] : VEC[i][2]),
                        "R1/R2 spacing", k - last,
                        (n % 2 == 0) ? VEC[i][1] : VEC[i][2]);
                    last = k;
                    n++;
                end
            end
            chk(n == 4, "R8 pulse count", n, 4);
        end

        // R4: disabled with word 0 gives no pulses
        pcount = 0;
        for (int j = 0; j < 10; j++) begin
            tick(1'b0, div_t'(0), p);
            if (p) pcount++;
        end
        chk(pcount == 0, "R4 disabled quiet", pcount, 0);

        // R4: drop enable mid-period, re-enable restarts with short length
        tick(1'b0, div_t'(15), p);
        for (int j = 0; j < 5; j++) tick(1'b1, div_t'(15), p);
        tick(1'b0, div_t'(15), p);
        chk(p == 1'b0, "R4 drop same cycle", int'(p), 0);
        tick(1'b0, div_t'(15), p);
        k = 0;
        last = 0;
        n = 0;
        while (n < 2 && k < 100) begin
            tick(1'b1, div_t'(15), p);
            k++;
            if (p) begin
                chk((k - last) == ((n == 0) ? 8 : 9), "R4 restart phase",
                    k - last, (n == 0) ? 8 : 9);
                last = k;
                n++;
            end
        end

        // R5: change word mid-period; pulses expected at 8, 10, 12
        tick(1'b0, div_t'(14), p);
        tick(1'b0, div_t'(14), p);
        k = 0;
        n = 0;
        while (n < 3 && k < 100) begin
            tick(1'b1, (k >= 2) ? div_t'(2) : div_t'(14), p);
            k++;
            if (p) begin
                chk(k == 8 + 2 * n, "R5 adopt at boundary", k, 8 + 2 * n);
                n++;
            end
        end
        tick(1'b0, div_t'(0), p);

        // R7: helper function
        chk(calc_divider(64'd600000000, 64'd75000000) == div_t'(14),
            "R7 exact", int'(calc_divider(64'd600000000, 64'd75000000)), 14);
        chk(calc_divider(64'd600000000, 64'd148500000) == div_t'(6),
            "R7 round", int'(calc_divider(64'd600000000, 64'd148500000)), 6);
        chk(calc_divider(64'd600000000, 64'd33300000) == div_t'(34),
            "R7 round", int'(calc_divider(64'd600000000, 64'd33300000)), 34);
        chk(calc_divider(64'd600000000, 64'd300000000) == div_t'(2),
            "R7 half", int'(calc_divider(64'd600000000, 64'd300000000)), 2);
        chk(calc_divider(64'd600000000, 64'd1000000) == div_t'(255),
            "R7 clamp high", int'(calc_divider(64'd600000000, 64'd1000000)), 255);
        chk(calc_divider(64'd600000000, 64'd1000000000) == div_t'(0),
            "R7 clamp low", int'(calc_divider(64'd600000000, 64'd1000000000)), 0);
        chk(calc_divider(64'd600000000, 64'd0) == div_t'(255),
            "R7 zero target", int'(calc_divider(64'd600000000, 64'd0)), 255);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule